// File: doc/BRIEF.md
# Audio Serial Transmit Clock Generator

This block makes the two transmit clocks of an audio serial port, all in the domain of one functional reference clock. The first stage gives a high-frequency master clock. It comes either from an internal counter that divides the reference by 1 to 4096, or from an external master-clock pin. The second stage gives the bit clock. It comes either from a counter that divides the master clock by 1 to 32, or from an external bit-clock pin. Each stage has a polarity bit that can invert its result.

Each generated clock is a registered level. It has a single-cycle strobe that marks the rising edge of that level. The bit-clock strobe is the edge on which transmit data shifts. External pins are synchronized first and then edge-detected.

Three write-only registers set up the block: one for the master stage, one for the bit stage and one for pin direction. Two direction bits decide whether each clock is driven out. Software should set those bits only after it has configured the stage that drives the pin.

Top module: `tx_clkgen`

## Requirements
- R1: Address 0 holds the master-stage fields: mode in bit 15 (1 = internal divider), polarity in bit 14, and divide-minus-one in bits 11:0. In internal mode with field value H, the gap between `hf_stb` pulses is H+1 reference cycles and `hf_clk_o` is high for ceil((H+1)/2) of them. This holds up to H = 4095.
- R2: When the divide ratio is odd, the high phase of `hf_clk_o` is one cycle longer than the low phase.
- R3: A master divide field of 0 gives a `hf_stb` pulse on every reference cycle.
- R4: With bit 15 clear, `hf_clk_o` follows the synchronized `hf_pin_in` within 5 cycles. There is one `hf_stb` per pin rising edge, and the master divide field has no effect.
- R5: Setting the master polarity bit inverts `hf_clk_o`. With an internal divider, the high phase then becomes floor((H+1)/2) cycles.
- R6: Address 1 holds the bit-stage fields: mode in bit 5 (1 = internal) and divide-minus-one in bits 4:0. With field value B and the master stage at H+1 cycles, `shift_stb` repeats every (B+1)(H+1) cycles, and `bclk_o` is high for ceil((B+1)/2)(H+1) of them. This holds up to B = 31.
- R7: Bit 7 of address 1 inverts `bclk_o`. `shift_stb` always marks a cycle in which `bclk_o` has just gone high.
- R8: With bit 5 clear, `bclk_o` follows the synchronized `bclk_pin_in` within 5 cycles, and the master stage settings have no effect on it.
- R9: Address 2 holds pin directions: bit 27 drives `hf_oe` and bit 26 drives `bclk_oe`. A value of 1 means output. The new value shows one cycle after the write.
- R10: A new divide value takes effect only at the next terminal count of its stage. The period that was running when the write happened completes at its old length.
- R11: After reset both stages are in external mode with divide fields, polarities and directions at zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 master, 1 bit, 2 direction |
| cfg_wdata | input | 32 | Register write data |
| hf_pin_in | input | 1 | External master-clock pin level |
| bclk_pin_in | input | 1 | External bit-clock pin level |
| hf_clk_o | output | 1 | Master clock level after polarity |
| hf_stb | output | 1 | Rising-edge strobe of `hf_clk_o` |
| hf_oe | output | 1 | Drive enable for the master-clock pin |
| bclk_o | output | 1 | Bit clock level after polarity |
| shift_stb | output | 1 | Transmit shift strobe, rising edge of `bclk_o` |
| bclk_oe | output | 1 | Drive enable for the bit-clock pin |

## Verification
A counter in either divider that has gone off its sequence shows at the ports within one output period. It appears as a wrong gap between strobes or a wrong count of high cycles inside that gap. A held divide value that was loaded at the wrong moment shows as a shortened period right after a write. A wrong source or polarity choice shows as a stage level that disagrees with its pin or its expected phase within a few cycles of the pin changing.

// File: rtl/tx_clkgen_pkg.sv
package tx_clkgen_pkg;
  localparam int CFG_W      = 32;
  localparam int HF_DIV_W   = 12;
  localparam int BK_DIV_W   = 5;
  localparam logic [1:0] A_HF  = 2'd0;
  localparam logic [1:0] A_BK  = 2'd1;
  localparam logic [1:0] A_DIR = 2'd2;
  localparam int HF_MODE_B  = 15;
  localparam int HF_POL_B   = 14;
  localparam int BK_MODE_B  = 5;
  localparam int BK_POL_B   = 7;
  localparam int DIR_HF_B   = 27;
  localparam int DIR_BK_B   = 26;
endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         src_tick,
  input  logic [W-1:0] ratio_m1,
  output logic         lvl,
  output logic         rise_stb,
  output logic         fall_stb
);
  logic [W-1:0] cnt, act;
  logic [W:0]   hi_len, nxt;
  logic         term;

  assign hi_len = ({1'b0, act} + (W+1)'(2)) >> 1;
  assign nxt    = {1'b0, cnt} + (W+1)'(1);
  assign term   = (cnt == act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act      <= '0;
      lvl      <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      if (src_tick) begin
        if (term) begin
          cnt      <= '0;
          act      <= ratio_m1;
          lvl      <= 1'b1;
          rise_stb <= 1'b1;
          fall_stb <= (act == '0);
        end else begin
          cnt <= cnt + W'(1);
          if (nxt == hi_len) begin
            lvl      <= 1'b0;
            fall_stb <= 1'b1;
          end
        end
      end
    end
  end

  // R10
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(src_tick && term) |=> $stable(act));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !src_tick |=> ($stable(cnt) && $stable(lvl)));

  // R2
  fall_low_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_stb && !rise_stb) |-> !lvl);
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel (
  input  logic clk,
  input  logic rst,
  input  logic use_int,
  input  logic invert,
  input  logic int_lvl,
  input  logic int_rise,
  input  logic int_fall,
  input  logic pin_in,
  output logic lvl_o,
  output logic stb_o
);
  logic s1, s2, s3;
  logic raw_lvl, raw_rise, raw_fall;

  always_comb begin
    raw_lvl  = use_int ? int_lvl  : s2;
    raw_rise = use_int ? int_rise : (s2 & ~s3);
    raw_fall = use_int ? int_fall : (~s2 & s3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      lvl_o <= 1'b0;
      stb_o <= 1'b0;
    end else begin
      s1    <= pin_in;
      s2    <= s1;
      s3    <= s2;
      lvl_o <= raw_lvl ^ invert;
      stb_o <= invert ? raw_fall : raw_rise;
    end
  end

  // R4
  ext_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (!use_int && stb_o) |=> !stb_o || $past(use_int));
endmodule

// File: rtl/tx_clkgen.sv
module tx_clkgen
  import tx_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hf_pin_in,
  input  logic             bclk_pin_in,
  output logic             hf_clk_o,
  output logic             hf_stb,
  output logic             hf_oe,
  output logic             bclk_o,
  output logic             shift_stb,
  output logic             bclk_oe
);
  logic                hf_mode, hf_pol, bk_mode, bk_pol;
  logic [HF_DIV_W-1:0] hf_div;
  logic [BK_DIV_W-1:0] bk_div;
  logic                hd_lvl, hd_rise, hd_fall;
  logic                bd_lvl, bd_rise, bd_fall;
  logic                cfg_unused;

  assign cfg_unused = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      hf_mode <= 1'b0;
      hf_pol  <= 1'b0;
      hf_div  <= '0;
      bk_mode <= 1'b0;
      bk_pol  <= 1'b0;
      bk_div  <= '0;
      hf_oe   <= 1'b0;
      bclk_oe <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_HF: begin
          hf_mode <= cfg_wdata[HF_MODE_B];
          hf_pol  <= cfg_wdata[HF_POL_B];
          hf_div  <= cfg_wdata[HF_DIV_W-1:0];
        end
        A_BK: begin
          bk_mode <= cfg_wdata[BK_MODE_B];
          bk_pol  <= cfg_wdata[BK_POL_B];
          bk_div  <= cfg_wdata[BK_DIV_W-1:0];
        end
        A_DIR: begin
          hf_oe   <= cfg_wdata[DIR_HF_B];
          bclk_oe <= cfg_wdata[DIR_BK_B];
        end
        default: ;
      endcase
    end
  end

  clkdiv_stage #(.W(HF_DIV_W)) u_hf_div (
    .clk(clk), .rst(rst), .src_tick(1'b1), .ratio_m1(hf_div),
    .lvl(hd_lvl), .rise_stb(hd_rise), .fall_stb(hd_fall)
  );

  clk_src_sel u_hf_sel (
    .clk(clk), .rst(rst), .use_int(hf_mode), .invert(hf_pol),
    .int_lvl(hd_lvl), .int_rise(hd_rise), .int_fall(hd_fall),
    .pin_in(hf_pin_in), .lvl_o(hf_clk_o), .stb_o(hf_stb)
  );

  clkdiv_stage #(.W(BK_DIV_W)) u_bk_div (
    .clk(clk), .rst(rst), .src_tick(hf_stb), .ratio_m1(bk_div),
    .lvl(bd_lvl), .rise_stb(bd_rise), .fall_stb(bd_fall)
  );

  clk_src_sel u_bk_sel (
    .clk(clk), .rst(rst), .use_int(bk_mode), .invert(bk_pol),
    .int_lvl(bd_lvl), .int_rise(bd_rise), .int_fall(bd_fall),
    .pin_in(bclk_pin_in), .lvl_o(bclk_o), .stb_o(shift_stb)
  );

  // R9
  dir_hf_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == A_DIR) |=> (hf_oe == $past(cfg_wdata[DIR_HF_B])));

  // R9
  dir_bk_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == A_DIR) |=> (bclk_oe == $past(cfg_wdata[DIR_BK_B])));
endmodule

// File: tb/test_tx_clkgen.sv
`timescale 1ns/1ps
module test_tx_clkgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic hf_pin_in = 1'b0;
  logic bclk_pin_in = 1'b0;
  logic hf_clk_o, hf_stb, hf_oe, bclk_o, shift_stb, bclk_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  int hf_run = 0, hf_hirun = 0, hf_per = 0, hf_hi = 0, hf_np = 0;
  int bk_run = 0, bk_hirun = 0, bk_per = 0, bk_hi = 0, bk_np = 0;
  int bad_shift = 0;

  always #2 clk = ~clk;

  tx_clkgen i_tx_clkgen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hf_pin_in(hf_pin_in), .bclk_pin_in(bclk_pin_in),
    .hf_clk_o(hf_clk_o), .hf_stb(hf_stb), .hf_oe(hf_oe),
    .bclk_o(bclk_o), .shift_stb(shift_stb), .bclk_oe(bclk_oe)
  );

  always @(negedge clk) begin
    cycles++;
    if (hf_stb) begin
      hf_per = hf_run; hf_hi = hf_hirun;
      hf_run = 1; hf_hirun = int'(hf_clk_o); hf_np++;
    end else begin
      hf_run++; hf_hirun += int'(hf_clk_o);
    end
    if (shift_stb) begin
      bk_per = bk_run; bk_hi = bk_hirun;
      bk_run = 1; bk_hirun = int'(bclk_o); bk_np++;
      if (!bclk_o) bad_shift++;
    end else begin
      bk_run++; bk_hirun += int'(bclk_o);
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic wait_hf(input int n);
    int s;
    s = hf_np;
    while (hf_np < s + n) tick(1);
  endtask

  task automatic wait_bk(input int n);
    int s;
    s = bk_np;
    while (bk_np < s + n) tick(1);
  endtask

  function automatic logic [31:0] hf_word(input bit m, input bit p, input int h);
    return (32'(m) << 15) | (32'(p) << 14) | 32'(h & 12'hFFF);
  endfunction

  function automatic logic [31:0] bk_word(input bit m, input bit p, input int b);
    return (32'(m) << 5) | (32'(p) << 7) | 32'(b & 5'h1F);
  endfunction

  task automatic t_reset;
    check("R11 hf_clk_o", int'(hf_clk_o), 0);
    check("R11 hf_stb", int'(hf_stb), 0);
    check("R11 bclk_o", int'(bclk_o), 0);
    check("R11 shift_stb", int'(shift_stb), 0);
    check("R11 oe", int'({hf_oe, bclk_oe}), 0);
  endtask

  task automatic t_hf_div(input string req, input int h, input bit p);
    int n;
    n = h + 1;
    wr(2'd0, hf_word(1'b1, p, h));
    wait_hf(3);
    check({req, " period"}, hf_per, n);
    check({req, " high"}, hf_hi, p ? n / 2 : (n + 1) / 2);
  endtask

  task automatic t_hf_ext(input bit p);
    int s;
    wr(2'd0, hf_word(1'b0, p, 5));
    hf_pin_in = 1'b0; tick(6);
    s = hf_np;
    hf_pin_in = 1'b1; tick(5);
    check("R4 follow high", int'(hf_clk_o), int'(1'b1 ^ p));
    if (!p) check("R4 single strobe", hf_np - s, 1);
    hf_pin_in = 1'b0; tick(5);
    check("R4 follow low", int'(hf_clk_o), int'(p));
  endtask

  task automatic t_runt;
    wr(2'd0, hf_word(1'b1, 1'b0, 9));
    wait_hf(3);
    wait_hf(1);
    tick(2);
    wr(2'd0, hf_word(1'b1, 1'b0, 3));
    wait_hf(1);
    check("R10 old period completes", hf_per, 10);
    wait_hf(1);
    check("R10 new period", hf_per, 4);
  endtask

  task automatic t_bk_div(input string req, input int h, input int b, input bit p);
    wr(2'd0, hf_word(1'b1, 1'b0, h));
    wr(2'd1, bk_word(1'b1, p, b));
    wait_bk(3);
    check({req, " period"}, bk_per, (b + 1) * (h + 1));
    check({req, " high"}, bk_hi, (p ? (b + 1) / 2 : (b + 2) / 2) * (h + 1));
  endtask

  task automatic t_bk_ext(input bit p);
    wr(2'd0, hf_word(1'b1, 1'b0, 0));
    wr(2'd1, bk_word(1'b0, p, 3));
    bclk_pin_in = 1'b0; tick(6);
    bclk_pin_in = 1'b1; tick(5);
    check("R8 follow high", int'(bclk_o), int'(1'b1 ^ p));
    bclk_pin_in = 1'b0; tick(5);
    check("R8 follow low", int'(bclk_o), int'(p));
  endtask

  task automatic t_dir;
    wr(2'd2, 32'h0800_0000);
    check("R9 hf_oe set", int'(hf_oe), 1);
    check("R9 bclk_oe clear", int'(bclk_oe), 0);
    wr(2'd2, 32'h0400_0000);
    check("R9 hf_oe clear", int'(hf_oe), 0);
    check("R9 bclk_oe set", int'(bclk_oe), 1);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_hf_div("R1 even", 9, 1'b0);
    t_hf_div("R2 odd", 6, 1'b0);
    t_hf_div("R3 bypass", 0, 1'b0);
    t_hf_div("R1 max", 4095, 1'b0);
    t_hf_div("R5 invert", 4, 1'b1);
    t_hf_ext(1'b0);
    t_hf_ext(1'b1);
    t_runt();
    t_bk_div("R6 even", 2, 3, 1'b0);
    t_bk_div("R6 odd", 2, 4, 1'b0);
    t_bk_div("R6 max", 1, 31, 1'b0);
    t_bk_div("R7 invert", 2, 4, 1'b1);
    check("R7 shift on high", bad_shift, 0);
    t_bk_ext(1'b0);
    t_bk_ext(1'b1);
    t_dir();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule